// File: doc/BRIEF.md
# BPSK Carrier Phase Recovery Loop

This block locks a receiver to the carrier phase of a BPSK signal that has already been brought down to complex baseband and passed through a matched filter. Each valid I/Q sample is turned through the current phase estimate by a complex rotator. The rotator takes its cosine and sine factors from a table addressed by the upper bits of a phase accumulator. The sign of the rotated in-phase value serves as a hard symbol decision. That decision times the rotated quadrature value gives a phase error.

A proportional-plus-integral filter turns the error into a phase step, and the accumulator adds the step up. A fixed phase offset is therefore pulled out by the proportional path, and a steady frequency offset is followed by the integral path. The derotated samples go on to symbol timing recovery. A lock flag reports when the proportional error term has stayed small for a run of consecutive updates. The two loop gains are power-of-two shifts whose values are taken from input pins while reset is held.

Top module: `costas_carrier_rec`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block clears out_valid, out_i, out_q, locked, the phase accumulator and the integrator. The first sample after reset is therefore rotated by a phase of zero.
- R2: Each sample accepted with in_valid high appears one clock later with out_valid high. The outputs are out_i = round((I·C + Q·S)/2^14) and out_q = round((Q·C − I·S)/2^14), where C and S are the cosine and sine of the table phase on a 16384 scale, and rounding adds 2^13 before an arithmetic right shift by 14. At table phase zero (C=16384, S=0) the outputs equal the inputs exactly.
- R3: The rotated results are clamped to the range −32768 to 32767 rather than wrapped.
- R4: The error is the rotated Q value when the rotated I value is zero or positive, and its negation when the rotated I value is negative (a zero I counts as +1). A zero rotated Q leaves the phase unchanged.
- R5: The integrator adds error>>>ki on each update. The phase step is (error>>>kp) plus the updated integrator, and it is added to the 16-bit accumulator modulo 2^16. The top 8 accumulator bits address a 256-step sine/cosine table built from one stored quarter wave, where one count equals 2π/65536 rad.
- R6: Given a constant input phase offset within ±90°, the loop drives the rotated Q toward zero and the rotated I toward the signal amplitude.
- R7: Given a constant input frequency offset, the integrator settles on the per-sample phase advance and the rotated Q stays near zero.
- R8: While in_valid is low, out_valid is low, out_i and out_q hold their values, and the accumulator, integrator and lock state do not change, whatever the data inputs carry.
- R9: locked rises on the update that completes 64 consecutive updates with |error>>>kp| below 64. It falls on the first update that breaks that bound.
- R10: kp_shift and ki_shift are captured only while rst_n is low. Changing them afterwards has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| kp_shift | input | 4 | Proportional gain shift, captured during reset |
| ki_shift | input | 4 | Integral gain shift, captured during reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | Signed in-phase sample |
| in_q | input | 16 | Signed quadrature sample |
| out_valid | output | 1 | Rotated sample strobe, one cycle after in_valid |
| out_i | output | 16 | Signed rotated in-phase sample |
| out_q | output | 16 | Signed rotated quadrature sample |
| locked | output | 1 | Carrier lock indicator |

## Verification
The assertions assume that in_valid is low on every reset cycle. They also assume the gain pins settle before rst_n is released, and the bench drives all inputs at the falling edge so that both hold. The identity-rotation property assumes a zero table phase gives unity cosine and zero sine. The bench keeps every phase and frequency scenario inside the ±90° pull-in range and keeps signal amplitudes such that only the dedicated saturation samples reach full scale.

// File: rtl/costas_pkg.sv
// Package: shared helpers for the carrier recovery loop.
// Holds the constant function that fills the quarter-wave sine table.
// Assumes the function is evaluated only at elaboration.
package costas_pkg;

    // pi scaled by 2^30
    localparam longint PI_Q30 = 64'sd3373259426;

    // Sine of k*pi/(2*quarter), scaled by 2^amp_bits, from a Taylor series in Q30.
    function automatic int unit_sine(input int k, input int quarter, input int amp_bits);
        longint x;
        longint t;
        longint s;
        if (k >= quarter) return (1 << amp_bits);
        x = (longint'(k) * PI_Q30) / longint'(2 * quarter);
        t = x;
        s = x;
        for (int n = 2; n <= 12; n += 2) begin
            t = -((((t * x) >>> 30) * x) >>> 30) / longint'(n * (n + 1));
            s = s + t;
        end
        return int'((s * (64'sd1 <<< amp_bits) + (64'sd1 <<< 29)) >>> 30);
    endfunction

endpackage

// File: rtl/costas_trig_lut.sv
// Module: cosine and sine lookup for one phase index.
// Stores one quarter wave (QN+1 points) and unfolds it into the four quadrants.
// Assumes LW >= 3; the amplitude is 2^FRAC and must fit in CW signed bits.
module costas_trig_lut
    import costas_pkg::*;
#(
    parameter int LW   = 8,
    parameter int FRAC = 14,
    parameter int CW   = 16
) (
    input  logic [LW-1:0]        idx,
    output logic signed [CW-1:0] cos_o,
    output logic signed [CW-1:0] sin_o
);
    localparam int QN = 1 << (LW - 2);
    localparam int AW = LW - 1;

    logic signed [CW-1:0] qtab [0:QN];
    logic signed [CW-1:0] val  [2];

    for (genvar g = 0; g <= QN; g++) begin : g_tab
        assign qtab[g] = CW'(unit_sine(g, QN, FRAC));
    end

    // way 0 gives the sine of idx, way 1 the sine of idx + quarter (cosine)
    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [LW-1:0]        addr;
        logic [AW-1:0]        ix;
        logic signed [CW-1:0] mag;
        assign addr = idx + LW'(w * QN);
        // mirror the quarter wave and apply the sign of the half wave
        always_comb begin
            ix     = addr[LW-2] ? (AW'(QN) - AW'(addr[LW-3:0])) : AW'(addr[LW-3:0]);
            mag    = qtab[ix];
            val[w] = addr[LW-1] ? -mag : mag;
        end
    end

    assign sin_o = val[0];
    assign cos_o = val[1];

endmodule

// File: rtl/costas_rotator.sv
// Module: complex derotation of one I/Q sample.
// Computes I*C+Q*S and Q*C-I*S, rounds half up at bit FRAC, clamps to DW bits.
// Assumes C and S are scaled by 2^FRAC; purely combinational.
module costas_rotator #(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int FRAC = 14
) (
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    input  logic signed [CW-1:0] cos_c,
    input  logic signed [CW-1:0] sin_c,
    output logic signed [DW-1:0] rot_i,
    output logic signed [DW-1:0] rot_q
);
    localparam int MW = DW + CW;
    localparam int PW = MW + 1;
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);
    localparam logic signed [PW-1:0] VMAX = PW'((1 << (DW - 1)) - 1);
    localparam logic signed [PW-1:0] VMIN = -PW'(1 << (DW - 1));

    logic signed [MW-1:0] p_ic, p_qs, p_qc, p_is;
    logic signed [PW-1:0] acc_i, acc_q, rnd_i, rnd_q;

    // clamp a rounded value into the output range
    function automatic logic signed [DW-1:0] clamp(input logic signed [PW-1:0] v);
        if (v > VMAX) return DW'(VMAX);
        if (v < VMIN) return DW'(VMIN);
        return DW'(v);
    endfunction

    // four partial products at full width
    always_comb begin
        p_ic = in_i * cos_c;
        p_qs = in_q * sin_c;
        p_qc = in_q * cos_c;
        p_is = in_i * sin_c;
    end

    // sum, round and clamp both rails
    always_comb begin
        acc_i = PW'(p_ic) + PW'(p_qs);
        acc_q = PW'(p_qc) - PW'(p_is);
        rnd_i = (acc_i + HALF) >>> FRAC;
        rnd_q = (acc_q + HALF) >>> FRAC;
        rot_i = clamp(rnd_i);
        rot_q = clamp(rnd_q);
    end

endmodule

// File: rtl/costas_loop_filter.sv
// Module: PI loop filter, phase accumulator and lock detector.
// On each update: integ += err>>>ki; phase += (err>>>kp) + integ.
// Gains are shift amounts captured while reset is low. Assumes upd is a one-cycle strobe.
module costas_loop_filter #(
    parameter int EW       = 17,
    parameter int PW       = 16,
    parameter int LW       = 8,
    parameter int IW       = 24,
    parameter int SHW      = 4,
    parameter int LOCK_RUN = 64,
    parameter int LOCK_THR = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SHW-1:0]       kp_in,
    input  logic [SHW-1:0]       ki_in,
    input  logic                 upd,
    input  logic signed [EW-1:0] err,
    output logic [LW-1:0]        theta_idx,
    output logic                 locked
);
    localparam int RCW = $clog2(LOCK_RUN + 1);
    localparam logic [EW-1:0]  THR_V  = EW'(LOCK_THR);
    localparam logic [RCW-1:0] RUN_V  = RCW'(LOCK_RUN);
    localparam logic [RCW-1:0] LAST_V = RCW'(LOCK_RUN - 1);

    logic [SHW-1:0]       kp_q, ki_q;
    logic signed [IW-1:0] integ_q, integ_n, step;
    logic [PW-1:0]        theta_q;
    logic [RCW-1:0]       run_q;
    logic signed [EW-1:0] prop, ipart;
    logic [EW-1:0]        prop_mag;
    logic                 calm;

    // gain shifts follow the pins only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kp_q <= kp_in;
            ki_q <= ki_in;
        end
    end

    // proportional and integral terms and the resulting phase step
    always_comb begin
        prop     = err >>> kp_q;
        ipart    = err >>> ki_q;
        integ_n  = integ_q + IW'(ipart);
        step     = integ_n + IW'(prop);
        prop_mag = prop[EW-1] ? EW'(-prop) : EW'(prop);
        calm     = prop_mag < THR_V;
    end

    // integrator and phase accumulator advance only on an update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            integ_q <= '0;
            theta_q <= '0;
        end else if (upd) begin
            integ_q <= integ_n;
            theta_q <= theta_q + step[PW-1:0];
        end
    end

    // count consecutive calm updates and raise lock at the end of the run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            locked <= 1'b0;
        end else if (upd) begin
            run_q  <= calm ? ((run_q == RUN_V) ? run_q : run_q + 1'b1) : '0;
            locked <= calm && (run_q >= LAST_V);
        end
    end

    assign theta_idx = theta_q[PW-1 -: LW];

    // R8: nothing in the loop moves without an update
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(theta_q) && $stable(integ_q) && $stable(locked)));

    // R9: lock can only appear as the result of an update
    assert_lock_on_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(upd));

    // R10: captured gains are frozen once reset is released
    assert_gain_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(kp_q) && $stable(ki_q)));

endmodule

// File: rtl/costas_carrier_rec.sv
// Module: top of the decision-directed carrier phase recovery loop.
// Rotates each valid sample by the phase estimate, registers the result,
// and feeds sign(rot_i)*rot_q into the loop filter in the same cycle.
// Assumes in_valid is low during reset and samples are already matched-filtered.
module costas_carrier_rec #(
    parameter int DW       = 16,
    parameter int CW       = 16,
    parameter int FRAC     = 14,
    parameter int PHW      = 16,
    parameter int LW       = 8,
    parameter int IW       = 24,
    parameter int SHW      = 4,
    parameter int LOCK_RUN = 64,
    parameter int LOCK_THR = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SHW-1:0]       kp_shift,
    input  logic [SHW-1:0]       ki_shift,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_i,
    output logic signed [DW-1:0] out_q,
    output logic                 locked
);
    localparam int EW = DW + 1;

    logic [LW-1:0]        theta_idx;
    logic signed [CW-1:0] cos_v, sin_v;
    logic signed [DW-1:0] rot_i, rot_q;
    logic signed [EW-1:0] err;

    costas_trig_lut #(.LW(LW), .FRAC(FRAC), .CW(CW)) u_lut (
        .idx   (theta_idx),
        .cos_o (cos_v),
        .sin_o (sin_v)
    );

    costas_rotator #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_rot (
        .in_i  (in_i),
        .in_q  (in_q),
        .cos_c (cos_v),
        .sin_c (sin_v),
        .rot_i (rot_i),
        .rot_q (rot_q)
    );

    // hard decision on rot_i (zero counts as +1) times rot_q
    always_comb begin
        err = rot_i[DW-1] ? -EW'(rot_q) : EW'(rot_q);
    end

    costas_loop_filter #(
        .EW(EW), .PW(PHW), .LW(LW), .IW(IW), .SHW(SHW),
        .LOCK_RUN(LOCK_RUN), .LOCK_THR(LOCK_THR)
    ) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .kp_in     (kp_shift),
        .ki_in     (ki_shift),
        .upd       (in_valid),
        .err       (err),
        .theta_idx (theta_idx),
        .locked    (locked)
    );

    // register the rotated sample and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_i <= rot_i;
                out_q <= rot_q;
            end
        end
    end

    // R2: every accepted sample yields a strobe one cycle later
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: a zero table phase passes the sample through unchanged
    assert_identity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && theta_idx == '0) |=> (out_i == $past(in_i) && out_q == $past(in_q)));

    // R8: idle cycles keep the outputs and drop the strobe
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_i) && $stable(out_q)));

endmodule

// File: tb/sim_costas_carrier_rec.sv
// Bench: directed scenarios for the carrier recovery loop, one task each.
module sim_costas_carrier_rec;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam real TWO_PI    = 6.283185307179586;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  kp_shift = 4'd3;
    logic [3:0]  ki_shift = 4'd8;
    logic        in_valid = 1'b0;
    logic signed [15:0] in_i = '0;
    logic signed [15:0] in_q = '0;
    logic        out_valid;
    logic signed [15:0] out_i, out_q;
    logic        locked;

    int checks = 0;
    int errors = 0;
    int oi, oq, ov, lk;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    costas_carrier_rec u0 (
        .clk(clk), .rst_n(rst_n), .kp_shift(kp_shift), .ki_shift(ki_shift),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .locked(locked)
    );

    function automatic int rnd(input real x);
        return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
    endfunction

    task automatic chk(input string tag, input int act, input int exp, input int tol);
        checks++;
        if (act > exp + tol || act < exp - tol) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input int kp, input int ki);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0;
        kp_shift = 4'(kp); ki_shift = 4'(ki);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive one sample at the falling edge, capture outputs at the next one
    task automatic push(input int i, input int q);
        in_valid = 1'b1; in_i = 16'(i); in_q = 16'(q);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        oi = out_i; oq = out_q; ov = out_valid; lk = locked;
    endtask

    task automatic test_reset();
        do_reset(3, 8);
        chk("R1 out_valid after reset", out_valid, 0, 0);
        chk("R1 out_i after reset", out_i, 0, 0);
        chk("R1 out_q after reset", out_q, 0, 0);
        chk("R1 locked after reset", locked, 0, 0);
        push(1234, 0);
        chk("R1 zero phase out_i", oi, 1234, 0);
        chk("R2 out_valid one cycle later", ov, 1, 0);
    endtask

    // one large error step, an idle gap with noisy data, then a probe sample
    task automatic test_step_and_gap();
        int hi, hq;
        do_reset(3, 8);
        kp_shift = 4'd0; ki_shift = 4'd0; // must be ignored (R10)
        push(8000, 32767);
        chk("R2 identity out_i", oi, 8000, 0);
        chk("R2 identity out_q", oq, 32767, 0);
        hi = oi; hq = oq;
        for (int n = 0; n < 20; n++) begin
            in_i = 16'(n * 1711 - 9000); in_q = 16'(20000 - n * 913);
            @(negedge clk);
            chk("R8 out_valid low when idle", out_valid, 0, 0);
            chk("R8 out_i held when idle", out_i, hi, 0);
            chk("R8 out_q held when idle", out_q, hq, 0);
        end
        // step = 32767>>>3 + 32767>>>8 = 4222 -> table index 16 (22.5 deg)
        push(10000, 0);
        chk("R5 R10 rotated I at index 16", oi, rnd(10000.0 * $cos(TWO_PI * 16.0 / 256.0)), 2);
        chk("R5 R10 rotated Q at index 16", oq, rnd(-10000.0 * $sin(TWO_PI * 16.0 / 256.0)), 2);
    endtask

    task automatic test_gain_shift();
        do_reset(5, 8);
        push(8000, 32767);
        // step = 32767>>>5 + 127 = 1150 -> index 4
        push(10000, 0);
        chk("R10 R5 kp=5 rotated I", oi, rnd(10000.0 * $cos(TWO_PI * 4.0 / 256.0)), 2);
        chk("R10 R5 kp=5 rotated Q", oq, rnd(-10000.0 * $sin(TWO_PI * 4.0 / 256.0)), 2);
    endtask

    task automatic test_sign_zero();
        do_reset(3, 8);
        push(0, 4000);
        chk("R4 out_q with zero I", oq, 4000, 0);
        // rot_i = 0 counts as +1: step = 500 + 15 = 515 -> index 2
        push(10000, 0);
        chk("R4 zero I decided positive", oq, rnd(-10000.0 * $sin(TWO_PI * 2.0 / 256.0)), 2);
    endtask

    task automatic test_lock();
        do_reset(3, 8);
        for (int n = 0; n < 63; n++) push(5000, 0);
        chk("R9 not locked after 63 calm updates", lk, 0, 0);
        chk("R4 zero Q keeps identity", oi, 5000, 0);
        push(5000, 0);
        chk("R9 locked after 64 calm updates", lk, 1, 0);
        push(5000, 5000);
        chk("R9 lock drops on large error", lk, 0, 0);
    endtask

    task automatic test_phase_offset();
        real ph;
        ph = TWO_PI * 8192.0 / 65536.0;
        do_reset(3, 8);
        for (int n = 0; n < 2000; n++)
            push(rnd(8000.0 * $cos(ph)), rnd(8000.0 * $sin(ph)));
        chk("R6 rotated Q near zero", oq, 0, 400);
        chk("R6 rotated I near amplitude", oi, 8000, 500);
        chk("R6 R9 locked on phase offset", lk, 1, 0);
        push(32767, 32767);
        chk("R3 positive saturation", oi, 32767, 0);
        push(-32768, -32768);
        chk("R3 negative saturation", oi, -32768, 0);
    endtask

    task automatic test_freq_offset();
        int worst;
        real ph;
        worst = 0;
        ph = 0.0;
        do_reset(3, 8);
        for (int n = 0; n < 4000; n++) begin
            push(rnd(8000.0 * $cos(ph)), rnd(8000.0 * $sin(ph)));
            ph = ph + TWO_PI * 100.0 / 65536.0;
            if (n >= 3800) begin
                if (oq > worst) worst = oq;
                if (-oq > worst) worst = -oq;
            end
        end
        chk("R7 worst rotated Q under frequency offset", worst, 0, 600);
        chk("R7 R9 locked on frequency offset", lk, 1, 0);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        test_reset();
        test_step_and_gap();
        test_gain_shift();
        test_sign_zero();
        test_lock();
        test_phase_offset();
        test_freq_offset();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule